// File: doc/BRIEF.md
# Taint-Grounded Redundancy Voter

This block runs a small combinational function next to its dual-rail taint-tracking copy. The function takes three operand vectors a, b and s and computes, bit by bit, `y = (a AND b) OR (NOT s)`. The tracking copy carries each signal as a pair of code bits (high, low), using these codes: untainted 0 is `00`, untainted 1 is `11`, and tainted is `01`. AND and OR act on each rail separately. NOT swaps the rails and inverts them. The taint of a signal is the XOR of its two rails.

In redundancy mode, every input taint is forced to zero. Both rails of each input then carry the data value, so both rails of each tracking output must equal the functional output. That gives three copies of every result bit. The block takes a bitwise 2-of-3 majority of them, raises a fault flag when any bit's copies disagree, and reports no taint.

In tracking mode, the real taints are used. The result comes from the functional copy, the fault flag is held low, and the per-bit taint is reported. Stuck-at injection inputs on each of the three copies serve as test hooks. All outputs are registered one cycle after the inputs.

Top module: `taint_redundancy_voter`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `result` = 0, `fault` = 0 and `taint` = 0.
- R2: In redundancy mode (`mode_redund` = 1) with no injection, `result` equals `(a & b) | ~s` and `fault` is 0.
- R3: In redundancy mode the taint inputs have no effect: `result` and `fault` are as for all-zero taints, and `taint` is 0.
- R4: In redundancy mode, a stuck value on any single copy of a bit (functional, high rail or low rail) that differs from the correct value sets `fault` to 1, while `result` still equals the correct value.
- R5: A stuck value equal to the correct value of that bit causes no fault.
- R6: In tracking mode (`mode_redund` = 0), `fault` is 0 and `result` is the functional copy, including any stuck value injected on it.
- R7: In tracking mode, `taint[i]` is 1 exactly when some assignment of values to the tainted inputs of bit i can change `y[i]`. Taint bits are `a_taint`, `b_taint` and `s_taint`, aligned with the data bits.
- R8: Faults on different bits in different copies are corrected independently, and `fault` is the OR over all bits.
- R9: Each output reflects the inputs sampled at the preceding rising edge of `clk`, which is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_redund | input | 1 | 1 = redundancy (taints grounded), 0 = taint tracking |
| a | input | W | Operand a |
| b | input | W | Operand b |
| s | input | W | Operand s (inverted term) |
| a_taint | input | W | Taint of a |
| b_taint | input | W | Taint of b |
| s_taint | input | W | Taint of s |
| inj_func | input | W | Per-bit stuck-at enable on the functional copy |
| inj_hi | input | W | Per-bit stuck-at enable on the high rail |
| inj_lo | input | W | Per-bit stuck-at enable on the low rail |
| inj_val | input | W | Value forced on enabled copies |
| result | output | W | Voted (redundancy) or functional (tracking) result, registered |
| fault | output | 1 | Copy disagreement flag, registered |
| taint | output | W | Per-bit output taint in tracking mode, registered |

## Verification
Every result is due one rising edge after the inputs that produced it: `result`, `fault` and `taint` are all registered at that edge from combinational logic. The driver applies one vector per falling edge and pushes its expected outputs in the same step. The monitor pops one item two time units after each rising edge. Because of this, an extra or missing pipeline stage shows up as a miscompare on every vector.

// File: rtl/trv_pkg.sv
package trv_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } rail_t;

  function automatic rail_t rail_enc(input logic d, input logic t);
    rail_t r;
    r.hi = d & ~t;
    r.lo = d | t;
    return r;
  endfunction

  function automatic rail_t rail_and(input rail_t x, input rail_t y);
    rail_t r;
    r.hi = x.hi & y.hi;
    r.lo = x.lo & y.lo;
    return r;
  endfunction

  function automatic rail_t rail_or(input rail_t x, input rail_t y);
    rail_t r;
    r.hi = x.hi | y.hi;
    r.lo = x.lo | y.lo;
    return r;
  endfunction

  function automatic rail_t rail_not(input rail_t x);
    rail_t r;
    r.hi = ~x.lo;
    r.lo = ~x.hi;
    return r;
  endfunction

endpackage

// File: rtl/trv_func_core.sv
module trv_func_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] s,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = (a[i] & b[i]) | ~s[i];
  end
endmodule

// File: rtl/trv_track_core.sv
module trv_track_core
  import trv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] s,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] s_t,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    rail_t ra, rb, rs, ro;
    always_comb begin
      ra = rail_enc(a[i], a_t[i]);
      rb = rail_enc(b[i], b_t[i]);
      rs = rail_enc(s[i], s_t[i]);
      ro = rail_or(rail_and(ra, rb), rail_not(rs));
    end
    assign hi[i] = ro.hi;
    assign lo[i] = ro.lo;
  end
endmodule

// File: rtl/trv_vote.sv
module trv_vote #(
  parameter int W = 8
) (
  input  logic [W-1:0] c0,
  input  logic [W-1:0] c1,
  input  logic [W-1:0] c2,
  output logic [W-1:0] maj,
  output logic [W-1:0] split
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign maj[i]   = (c0[i] & c1[i]) | (c0[i] & c2[i]) | (c1[i] & c2[i]);
    assign split[i] = (c0[i] ^ c1[i]) | (c0[i] ^ c2[i]);
  end
endmodule

// File: rtl/taint_redundancy_voter.sv
module taint_redundancy_voter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_redund,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] s,
  input  logic [W-1:0] a_taint,
  input  logic [W-1:0] b_taint,
  input  logic [W-1:0] s_taint,
  input  logic [W-1:0] inj_func,
  input  logic [W-1:0] inj_hi,
  input  logic [W-1:0] inj_lo,
  input  logic [W-1:0] inj_val,
  output logic [W-1:0] result,
  output logic         fault,
  output logic [W-1:0] taint
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] at_eff, bt_eff, st_eff;
  logic [W-1:0] f_raw, hi_raw, lo_raw;
  logic [W-1:0] f_cp, hi_cp, lo_cp;
  logic [W-1:0] voted, split;

  assign at_eff = mode_redund ? ZERO : a_taint;
  assign bt_eff = mode_redund ? ZERO : b_taint;
  assign st_eff = mode_redund ? ZERO : s_taint;

  trv_func_core #(.W(W)) u_func (.a(a), .b(b), .s(s), .y(f_raw));

  trv_track_core #(.W(W)) u_track (
    .a(a), .b(b), .s(s),
    .a_t(at_eff), .b_t(bt_eff), .s_t(st_eff),
    .hi(hi_raw), .lo(lo_raw)
  );

  assign f_cp  = (f_raw  & ~inj_func) | (inj_val & inj_func);
  assign hi_cp = (hi_raw & ~inj_hi)   | (inj_val & inj_hi);
  assign lo_cp = (lo_raw & ~inj_lo)   | (inj_val & inj_lo);

  trv_vote #(.W(W)) u_vote (
    .c0(f_cp), .c1(hi_cp), .c2(lo_cp), .maj(voted), .split(split)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      fault  <= 1'b0;
      taint  <= '0;
    end else if (mode_redund) begin
      result <= voted;
      fault  <= |split;
      taint  <= '0;
    end else begin
      result <= f_cp;
      fault  <= 1'b0;
      taint  <= hi_cp ^ lo_cp;
    end
  end
endmodule

// File: rtl/trv_guard.sv
module trv_guard #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_redund,
  input logic [W-1:0] inj_func,
  input logic [W-1:0] inj_hi,
  input logic [W-1:0] inj_lo,
  input logic [W-1:0] result,
  input logic         fault,
  input logic [W-1:0] taint
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == '0 && !fault && taint == '0)); // R1

  AST_CLEAN_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_redund) && $past((inj_func | inj_hi | inj_lo) == '0)) |-> !fault); // R2

  AST_REDUND_NO_TAINT: assert property (@(posedge clk) disable iff (rst)
    $past(mode_redund) |-> taint == '0); // R3

  AST_FAULT_NEEDS_INJ: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past((inj_func | inj_hi | inj_lo) != '0)); // R4

  AST_TRACK_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    $past(!mode_redund) |-> !fault); // R6
endmodule

bind taint_redundancy_voter trv_guard #(.W(W)) u_guard (
  .clk(clk), .rst(rst), .mode_redund(mode_redund),
  .inj_func(inj_func), .inj_hi(inj_hi), .inj_lo(inj_lo),
  .result(result), .fault(fault), .taint(taint)
);

// File: tb/test_taint_redundancy_voter.sv
`timescale 1ns/1ps
module test_taint_redundancy_voter;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_redund = 1'b1;
  logic [W-1:0] a = '0, b = '0, s = '0;
  logic [W-1:0] a_taint = '0, b_taint = '0, s_taint = '0;
  logic [W-1:0] inj_func = '0, inj_hi = '0, inj_lo = '0, inj_val = '0;
  logic [W-1:0] result;
  logic         fault;
  logic [W-1:0] taint;

  always #4 clk = ~clk;

  taint_redundancy_voter #(.W(W)) i_taint_redundancy_voter (
    .clk(clk), .rst(rst), .mode_redund(mode_redund),
    .a(a), .b(b), .s(s),
    .a_taint(a_taint), .b_taint(b_taint), .s_taint(s_taint),
    .inj_func(inj_func), .inj_hi(inj_hi), .inj_lo(inj_lo), .inj_val(inj_val),
    .result(result), .fault(fault), .taint(taint)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         flt;
    logic [W-1:0] tnt;
    bit           use_tnt;
    int           req;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] fmodel(input logic [W-1:0] x, y, z);
    return (x & y) | ~z;
  endfunction

  // R7: exact taint by enumerating values of the tainted inputs of each bit
  function automatic logic [W-1:0] tmodel(input logic [W-1:0] x, y, z,
                                          input logic [W-1:0] xt, yt, zt);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      logic seen0 = 1'b0, seen1 = 1'b0;
      for (int k = 0; k < 8; k++) begin
        logic xv, yv, zv, o;
        xv = xt[i] ? k[0] : x[i];
        yv = yt[i] ? k[1] : y[i];
        zv = zt[i] ? k[2] : z[i];
        o = (xv & yv) | ~zv;
        if (o) seen1 = 1'b1; else seen0 = 1'b1;
      end
      r[i] = seen0 & seen1;
    end
    return r;
  endfunction

  task automatic drive(input logic md, input logic [W-1:0] da, db, ds,
                       input logic [W-1:0] ta, tb, ts,
                       input logic [W-1:0] jf, jh, jl, jv,
                       input logic [W-1:0] e_res, input logic e_flt,
                       input logic [W-1:0] e_tnt, input bit use_t, input int req);
    exp_t e;
    @(negedge clk);
    mode_redund = md; a = da; b = db; s = ds;
    a_taint = ta; b_taint = tb; s_taint = ts;
    inj_func = jf; inj_hi = jh; inj_lo = jl; inj_val = jv;
    e.res = e_res; e.flt = e_flt; e.tnt = e_tnt; e.use_tnt = use_t; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: each result is due one rising edge after its vector (R9)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (result !== e.res || fault !== e.flt || (e.use_tnt && taint !== e.tnt)) begin
          n_bad++;
          $display("FAIL R%0d: result=%h fault=%b taint=%h, expected result=%h fault=%b taint=%h",
                   e.req, result, fault, taint, e.res, e.flt, e.tnt);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pa, pb, ps, f, nf;
    // R1: reset clears outputs despite active inputs
    drive(1'b1, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00,
          '0, 1'b0, '0, 1'b1, 1);
    @(negedge clk);
    rst = 1'b0;

    // R2 / R9: clean redundancy, several patterns back to back
    drive(1'b1, 8'hA5, 8'h3C, 8'hF0, '0, '0, '0, '0, '0, '0, '0,
          fmodel(8'hA5, 8'h3C, 8'hF0), 1'b0, '0, 1'b1, 2);
    drive(1'b1, 8'h00, 8'hFF, 8'hFF, '0, '0, '0, '0, '0, '0, '0,
          fmodel(8'h00, 8'hFF, 8'hFF), 1'b0, '0, 1'b1, 2);
    drive(1'b1, 8'hFF, 8'hFF, 8'h55, '0, '0, '0, '0, '0, '0, '0,
          fmodel(8'hFF, 8'hFF, 8'h55), 1'b0, '0, 1'b1, 9);

    // R3: taints ignored in redundancy mode
    drive(1'b1, 8'h96, 8'h69, 8'hC3, 8'hFF, 8'hFF, 8'hFF, '0, '0, '0, '0,
          fmodel(8'h96, 8'h69, 8'hC3), 1'b0, '0, 1'b1, 3);

    pa = 8'h5A; pb = 8'hF3; ps = 8'h2E;
    f = fmodel(pa, pb, ps); nf = ~f;
    // R4: single wrong copy, each copy in turn
    drive(1'b1, pa, pb, ps, '0, '0, '0, 8'h01, '0, '0, nf, f, 1'b1, '0, 1'b1, 4);
    drive(1'b1, pa, pb, ps, '0, '0, '0, '0, 8'h08, '0, nf, f, 1'b1, '0, 1'b1, 4);
    drive(1'b1, pa, pb, ps, '0, '0, '0, '0, '0, 8'h80, nf, f, 1'b1, '0, 1'b1, 4);
    drive(1'b1, pa, pb, ps, 8'hFF, '0, 8'hFF, '0, '0, 8'h20, nf, f, 1'b1, '0, 1'b1, 4);
    // R5: stuck value equal to correct value
    drive(1'b1, pa, pb, ps, '0, '0, '0, 8'hFF, '0, '0, f, f, 1'b0, '0, 1'b1, 5);
    drive(1'b1, pa, pb, ps, '0, '0, '0, '0, 8'h0F, 8'hF0, f, f, 1'b0, '0, 1'b1, 5);
    // R8: faults in different copies on different bits
    drive(1'b1, pa, pb, ps, '0, '0, '0, 8'h01, 8'h02, 8'h04, nf, f, 1'b1, '0, 1'b1, 8);

    // R7: tracking mode taints
    drive(1'b0, 8'hA5, 8'h3C, 8'hF0, 8'h0F, 8'hF0, 8'h33, '0, '0, '0, '0,
          fmodel(8'hA5, 8'h3C, 8'hF0), 1'b0,
          tmodel(8'hA5, 8'h3C, 8'hF0, 8'h0F, 8'hF0, 8'h33), 1'b1, 7);
    drive(1'b0, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, '0, '0, '0, '0,
          fmodel(8'hFF, 8'h00, 8'hFF), 1'b0,
          tmodel(8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00), 1'b1, 7);
    drive(1'b0, 8'hCC, 8'hAA, 8'h0F, 8'hFF, 8'hFF, 8'hFF, '0, '0, '0, '0,
          fmodel(8'hCC, 8'hAA, 8'h0F), 1'b0,
          tmodel(8'hCC, 8'hAA, 8'h0F, 8'hFF, 8'hFF, 8'hFF), 1'b1, 7);
    drive(1'b0, 8'h3C, 8'h3C, 8'h3C, 8'h00, 8'h00, 8'h00, '0, '0, '0, '0,
          fmodel(8'h3C, 8'h3C, 8'h3C), 1'b0, '0, 1'b1, 7);
    // R6: functional copy drives result, no fault even with rail disagreement
    drive(1'b0, pa, pb, ps, '0, '0, '0, 8'h03, '0, '0, nf,
          (f & ~8'h03) | (nf & 8'h03), 1'b0, '0, 1'b1, 6);
    drive(1'b0, pa, pb, ps, '0, '0, '0, '0, 8'hFF, '0, nf, f, 1'b0, '0, 1'b0, 6);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule